// File: doc/BRIEF.md
# Peripheral Interrupt Collector with Periodic Timer

The block collects the interrupt request lines of ten peripherals and turns them into one interrupt line for the processor. The lines are sorted into five groups: four general-purpose I/O banks, three LED drivers, a serial peripheral port, a two-wire management bus and a one-wire controller. A built-in periodic timer forms a sixth group. Each group has its own enable bit. A global enable sits over all groups, and a mode bit chooses how the combined request reaches the processor: as a level that follows it, or as a one-clock pulse on each rising transition.

Software reaches the block through four word registers on a simple synchronous bus. Writes take effect at the clock edge and reads are combinational. The status word shows the live request lines and the sticky timer request. The timer divides the clock by a power of two chosen by a 4-bit prescale value. It counts the resulting ticks up to a programmed terminal value and then raises its request. The request is cleared by rewriting the terminal value.

Top module: `irq_gather`

## Requirements
- R1: After reset, every register reads zero and `cpuIrq` is low.
- R2: The control word sits at byte offset 0x00. Bit 0 is the global enable, bit 1 selects edge mode, and bits 7..2 are group enables. Bits 15..8 read zero. A write whose address bits [1:0] are not zero changes no register.
- R3: The status word at offset 0x04 returns the live request lines in bits 9..0 and the sticky timer request in bit 10. In bits 9..0, bits 3..0 are I/O banks 0..3, bits 6..4 are LEDs 0..2, bit 7 is the serial port, bit 8 is the management bus and bit 9 is the one-wire controller. Writes to it have no effect.
- R4: Control bits 2, 3, 4, 5, 6 and 7 enable the groups I/O banks, LEDs, serial port, management bus, one-wire and timer, in that order. A group whose bit is 0 cannot cause an interrupt.
- R5: With control bit 0 at 0, `cpuIrq` stays low whatever the requests.
- R6: In level mode (control bit 1 = 0), `cpuIrq` equals, one clock later, the OR of the enabled groups gated by the global enable.
- R7: In edge mode (control bit 1 = 1), `cpuIrq` is high for exactly one clock, one clock after the combined request goes from 0 to 1. A second source that rises while the combined request is already high gives no new pulse.
- R8: The timer setup word at offset 0x08 holds the prescale value in bits 3..0 and the timer enable in bit 4. A written prescale value above 14 is stored as 14. Writing this word restarts the timer count.
- R9: While the timer is enabled, a tick occurs every 2^(prescale+1) clocks. After as many ticks as the terminal value, the timer request is set and counting starts again. A terminal value of 0 never sets it.
- R10: The terminal value sits at offset 0x0C. Once set, the timer request stays set until this word is written. Writing it clears the request and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 4 | Byte address, word aligned |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the address |
| periphReq | input | 10 | Peripheral request levels |
| cpuIrq | output | 1 | Interrupt line to the processor |

## Verification
The hardest state to reach is the timer request. It appears only after the programmed number of divided ticks, and it has to stay set across later timer periods until the terminal value is rewritten. The stimulus uses the smallest prescale and small terminal values so that requests appear within tens of cycles. It then waits through several further periods before clearing the request, and with a terminal value of zero it waits long enough to show that the request never appears. Edge mode is driven with overlapping sources from different groups, so that a second rise under an already-high combined request is exercised.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int GPIO_N  = 4;
  localparam int LED_N   = 3;
  localparam int NUM_SRC = GPIO_N + LED_N + 3;
  localparam int NUM_GRP = 6;
  localparam int CTRL_W  = 2 + NUM_GRP;
  localparam int PRE_W   = 4;
  localparam int PRE_MAX = 14;
  localparam int SET_W   = 16;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PRE  = 2'd2,
    SEL_SET  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrPre;
    logic    wrSet;
    regSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/irq_gather_ctl.sv
module irq_gather_ctl
  import irq_gather_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          stb
);
  logic       aligned;
  logic       wrEn;
  logic [1:0] wordIdx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[3:2];
  assign wrEn    = busSel & busWrite & aligned;

  always_comb begin
    stb.rdSel  = regSel_e'(wordIdx);
    stb.wrCtrl = wrEn && (wordIdx == SEL_CTRL);
    stb.wrPre  = wrEn && (wordIdx == SEL_PRE);
    stb.wrSet  = wrEn && (wordIdx == SEL_SET);
  end
endmodule

// File: rtl/irq_gather_timer.sv
module irq_gather_timer #(
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 14,
  parameter int SET_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadPre,
  input  logic [PRE_W:0]   preIn,
  input  logic             loadSet,
  input  logic [SET_W-1:0] setIn,
  output logic [PRE_W-1:0] preQ,
  output logic             enQ,
  output logic [SET_W-1:0] setQ,
  output logic             req
);
  localparam int CNT_W = PRE_MAX + 1;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLast;
  logic [SET_W-1:0] tickCnt;
  logic [PRE_W-1:0] preClamp;
  logic             tick;
  logic             lastTick;

  assign preClamp = (preIn[PRE_W-1:0] > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX)
                                                        : preIn[PRE_W-1:0];
  assign divLast  = {CNT_W{1'b1}} >> (PRE_MAX - int'(preQ));
  assign tick     = enQ && (divCnt == divLast);
  assign lastTick = (setQ != '0) && (tickCnt == setQ - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ    <= '0;
      enQ     <= 1'b0;
      setQ    <= '0;
      req     <= 1'b0;
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (loadPre) begin
      preQ    <= preClamp;
      enQ     <= preIn[PRE_W];
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (loadSet) begin
      setQ    <= setIn;
      req     <= 1'b0;
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (!enQ) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (tick) begin
      divCnt <= '0;
      if (lastTick) begin
        req     <= 1'b1;
        tickCnt <= '0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/irq_gather_dp.sv
module irq_gather_dp
  import irq_gather_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] periphReq,
  output logic [DATA_W-1:0]  rdata,
  output logic               cpuIrq,
  output logic               globalEn,
  output logic               edgeMode,
  output logic               timerEn,
  output logic               timerReq
);
  localparam int GRP_LO [NUM_GRP] = '{0, GPIO_N, GPIO_N + LED_N,
                                      GPIO_N + LED_N + 1, GPIO_N + LED_N + 2, NUM_SRC};
  localparam int GRP_HI [NUM_GRP] = '{GPIO_N - 1, GPIO_N + LED_N - 1, GPIO_N + LED_N,
                                      GPIO_N + LED_N + 1, GPIO_N + LED_N + 2, NUM_SRC};

  logic [CTRL_W-1:0]  ctrlQ;
  logic [NUM_SRC:0]   srcAll;
  logic [NUM_GRP-1:0] groupReq;
  logic               anyReq;
  logic               anyQ;
  logic               irqQ;
  logic [PRE_W-1:0]   preQ;
  logic [SET_W-1:0]   setQ;

  irq_gather_timer #(
    .PRE_W  (PRE_W),
    .PRE_MAX(PRE_MAX),
    .SET_W  (SET_W)
  ) i_timer (
    .clk    (clk),
    .rstN   (rstN),
    .loadPre(stb.wrPre),
    .preIn  (wdata[PRE_W:0]),
    .loadSet(stb.wrSet),
    .setIn  (wdata[SET_W-1:0]),
    .preQ   (preQ),
    .enQ    (timerEn),
    .setQ   (setQ),
    .req    (timerReq)
  );

  assign srcAll = {timerReq, periphReq};

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_group
    assign groupReq[g] = |srcAll[GRP_HI[g]:GRP_LO[g]];
  end

  assign globalEn = ctrlQ[0];
  assign edgeMode = ctrlQ[1];
  assign anyReq   = globalEn & (|(groupReq & ctrlQ[CTRL_W-1:2]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      anyQ  <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      if (stb.wrCtrl) ctrlQ <= wdata[CTRL_W-1:0];
      anyQ <= anyReq;
      irqQ <= edgeMode ? (anyReq & ~anyQ) : anyReq;
    end
  end

  assign cpuIrq = irqQ;

  always_comb begin
    rdata = '0;
    unique case (stb.rdSel)
      SEL_CTRL: rdata[CTRL_W-1:0] = ctrlQ;
      SEL_STAT: rdata[NUM_SRC:0]  = srcAll;
      SEL_PRE:  rdata[PRE_W:0]    = {timerEn, preQ};
      SEL_SET:  rdata[SET_W-1:0]  = setQ;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] periphReq,
  output logic               cpuIrq
);
  strobes_t stb;
  logic     globalEn;
  logic     edgeMode;
  logic     timerEn;
  logic     timerReq;
  logic     setWrite;

  irq_gather_ctl i_ctl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .stb     (stb)
  );

  irq_gather_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (busWdata),
    .periphReq(periphReq),
    .rdata    (busRdata),
    .cpuIrq   (cpuIrq),
    .globalEn (globalEn),
    .edgeMode (edgeMode),
    .timerEn  (timerEn),
    .timerReq (timerReq)
  );

  assign setWrite = stb.wrSet;
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk (
  input logic clk,
  input logic rstN,
  input logic cpuIrq,
  input logic globalEn,
  input logic edgeMode,
  input logic timerEn,
  input logic timerReq,
  input logic setWrite
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !cpuIrq);

  // R5
  global_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !cpuIrq);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeMode && cpuIrq) |=> !cpuIrq);

  // R9
  timer_from_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerReq) |-> $past(timerEn));

  // R10
  timer_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerReq && !setWrite) |=> timerReq);

  // R10
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    setWrite |=> !timerReq);
endmodule

bind irq_gather irq_gather_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuIrq  (cpuIrq),
  .globalEn(globalEn),
  .edgeMode(edgeMode),
  .timerEn (timerEn),
  .timerReq(timerReq),
  .setWrite(setWrite)
);

// File: tb/test_irq_gather.sv
`timescale 1ns/1ps
module test_irq_gather;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [9:0]  periphReq = '0;
  logic        cpuIrq;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  irq_gather i_irq_gather (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .periphReq(periphReq), .cpuIrq(cpuIrq)
  );

  // behavioural reference state
  int mCtrl, mPre, mEn, mSet, mDiv, mTick, mReq, mAnyQ, mIrq, mMode;

  function automatic int groupOf(int s);
    if (s < 4) return 0;
    if (s < 7) return 1;
    return s - 5;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mPre = 0; mEn = 0; mSet = 0; mDiv = 0;
      mTick = 0; mReq = 0; mAnyQ = 0; mIrq = 0; mMode = 0;
    end else begin
      int any;
      bit wr;
      int a;
      any = 0;
      for (int s = 0; s < 10; s++)
        if (periphReq[s] && ((mCtrl >> (2 + groupOf(s))) & 1)) any = 1;
      if (mReq != 0 && ((mCtrl >> 7) & 1)) any = 1;
      if ((mCtrl & 1) == 0) any = 0;
      mMode = (mCtrl >> 1) & 1;
      mIrq  = mMode ? (any && !mAnyQ) : any;
      mAnyQ = any;
      wr = busSel && busWrite && (busAddr[1:0] == 2'b00);
      a  = busAddr[3:2];
      if (wr && a == 0) mCtrl = busWdata & 16'hFF;
      if (wr && a == 2) begin
        mPre = ((busWdata & 15) > 14) ? 14 : (busWdata & 15);
        mEn = (busWdata >> 4) & 1; mDiv = 0; mTick = 0;
      end else if (wr && a == 3) begin
        mSet = busWdata; mReq = 0; mDiv = 0; mTick = 0;
      end else if (mEn == 0) begin
        mDiv = 0; mTick = 0;
      end else if (mDiv == (1 << (mPre + 1)) - 1) begin
        mDiv = 0;
        if (mSet != 0 && mTick + 1 == mSet) begin mReq = 1; mTick = 0; end
        else mTick = (mTick + 1) % 65536;
      end else begin
        mDiv = mDiv + 1;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      chk(int'(cpuIrq), mIrq, mMode ? "R7 edge output" : "R6 level output");
      if (busSel && !busWrite) begin
        case (busAddr[3:2])
          2'd0: chk(int'(busRdata), mCtrl, "R2 control read");
          2'd1: chk(int'(busRdata), (mReq << 10) | int'(periphReq), "R3 status read");
          2'd2: chk(int'(busRdata), (mEn << 4) | mPre, "R8 setup read");
          default: chk(int'(busRdata), mSet, "R10 terminal read");
        endcase
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdExp(input logic [3:0] a, input int exp, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #2 chk(int'(busRdata), exp, tag);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int pulses;
    idle(3);
    #1 chk(int'(cpuIrq), 0, "R1 reset output");
    rstN = 1'b1;
    rdExp(4'h0, 0, "R1 control after reset");
    rdExp(4'h4, 0, "R1 status after reset");
    rdExp(4'h8, 0, "R1 setup after reset");
    rdExp(4'hC, 0, "R1 terminal after reset");

    // R2: control readback and unaligned write
    wr(4'h0, 16'hFFFD);
    rdExp(4'h0, 'hFD, "R2 control fields");
    wr(4'h1, 16'h0000);
    rdExp(4'h0, 'hFD, "R2 unaligned write ignored");

    // R6 / R3: each source alone, level mode, all groups enabled
    for (int s = 0; s < 10; s++) begin
      @(negedge clk); periphReq = 10'(1 << s);
      idle(2);
      chk(int'(cpuIrq), 1, "R6 level follows source");
      rdExp(4'h4, 1 << s, "R3 status bit position");
      @(negedge clk); periphReq = '0;
      idle(2);
      chk(int'(cpuIrq), 0, "R6 level drops");
    end

    // R3: status write ignored
    wr(4'h4, 16'hFFFF);
    rdExp(4'h4, 0, "R3 status write ignored");
    rdExp(4'h0, 'hFD, "R3 status write leaves control");

    // R4: one group enabled at a time
    for (int g = 0; g < 5; g++) begin
      wr(4'h0, 16'(1 | (1 << (2 + g))));
      for (int s = 0; s < 10; s++) begin
        @(negedge clk); periphReq = 10'(1 << s);
        idle(2);
        chk(int'(cpuIrq), (groupOf(s) == g) ? 1 : 0, "R4 group gating");
        @(negedge clk); periphReq = '0;
        idle(1);
      end
    end

    // R5: global enable off
    wr(4'h0, 16'h00FC);
    @(negedge clk); periphReq = 10'h3FF;
    idle(4);
    chk(int'(cpuIrq), 0, "R5 global off");
    @(negedge clk); periphReq = '0;
    idle(2);

    // R7: edge mode with overlapping sources
    wr(4'h0, 16'h00FF);
    idle(2);
    pulses = 0;
    @(negedge clk); periphReq = 10'h001;
    for (int i = 0; i < 6; i++) begin @(negedge clk); #1 pulses += int'(cpuIrq); end
    periphReq = 10'h101;
    for (int i = 0; i < 6; i++) begin @(negedge clk); #1 pulses += int'(cpuIrq); end
    chk(pulses, 1, "R7 one pulse for overlapping sources");
    periphReq = '0;
    idle(3);
    @(negedge clk); periphReq = 10'h080;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); #1 pulses += int'(cpuIrq); end
    chk(pulses, 1, "R7 new pulse after drop");
    periphReq = '0;

    // R8: prescale clamp and enable bit
    wr(4'h8, 16'h001F);
    rdExp(4'h8, 'h1E, "R8 clamp to 14");
    wr(4'h8, 16'h000F);
    rdExp(4'h8, 'h0E, "R8 clamp without enable");
    wr(4'h8, 16'h0005);
    rdExp(4'h8, 'h05, "R8 plain value");

    // R9: timer request after terminal count, level mode, timer group only
    wr(4'h0, 16'h0081);
    wr(4'hC, 16'd3);
    wr(4'h8, 16'h0010);
    idle(2);
    rdExp(4'h4, 0, "R9 not yet expired");
    idle(8);
    rdExp(4'h4, 'h400, "R9 timer request set");
    chk(int'(cpuIrq), 1, "R9 timer drives output");
    idle(40);
    rdExp(4'h4, 'h400, "R10 request sticky");
    wr(4'hC, 16'd0);
    rdExp(4'h4, 0, "R10 cleared by terminal write");
    idle(100);
    rdExp(4'h4, 0, "R9 zero terminal never fires");

    // R9: larger prescale, edge mode pulse from timer
    wr(4'h0, 16'h0083);
    wr(4'h8, 16'h0012);
    wr(4'hC, 16'd2);
    idle(10);
    rdExp(4'h4, 0, "R9 prescale 2 not yet expired");
    pulses = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); #1 pulses += int'(cpuIrq); end
    chk(pulses, 1, "R7 timer edge pulse");
    rdExp(4'h4, 'h400, "R10 sticky after pulse");
    wr(4'h8, 16'h0000);
    wr(4'hC, 16'd1);
    idle(20);
    rdExp(4'h4, 0, "R9 disabled timer idle");

    idle(5);
    finishRun();
  end
endmodule